// File: doc/BRIEF.md
# Associative Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses through a small, fully associative table. Each table slot describes a pair of neighbouring virtual pages, one even and one odd. Each slot has its own page-size mask, its own address-space tag and a global flag. Each half of the pair carries its own physical frame number and four permission flags: valid, dirty, no-execute and no-read.

A lookup presents a virtual address, the current 8-bit address-space tag and an access kind. The unit searches every slot in parallel. One clock edge later it returns a registered result: a 3-bit result code, the physical address and a flag that marks the page writable. A separate write port replaces one whole slot, chosen by index. On reset every slot is marked invalidated, so lookups miss until software loads slots through that port.

Top module: `tlb_lookup_unit`

## Requirements
- R1: A lookup is sampled on the clock edge where `lk_req` is high. `rs_valid` and the result fields change on that same edge, which is one clock after the request is driven. `rs_valid` is low after any edge where `lk_req` was low.
- R2: While `rst` is high, `rs_valid` is low. Reset sets the invalidate flag of every slot, so until a slot is written every lookup returns result code 1 (no match).
- R3: A slot hits only when all three of these hold: its global flag is set or its tag equals `lk_asid`; its virtual page field equals the incoming address in every bit above the effective mask; and its invalidate flag is clear. If no slot hits, the result code is 1 (no match).
- R4: The effective mask is the slot mask ORed with 0x1FFF, so the smallest page pair is two 4 KB pages. Address bits above the effective mask take part in the compare, and bits inside it do not.
- R5: The odd half is chosen when the address bit at the highest set bit of the effective mask is 1. The physical address is the chosen half's frame number ORed with the address bits below that bit.
- R6: If the chosen half's valid flag (flag bit 0) is clear, the result code is 2 (invalid) for every access kind.
- R7: Access kinds are 0 fetch, 1 load, 2 store; the value 3 behaves as a load. A fetch to a half whose no-execute flag (bit 2) is set returns code 4. A load to a half whose no-read flag (bit 3) is set returns code 5. The no-execute flag does not affect loads or stores, and the no-read flag does not affect fetches or stores.
- R8: A store to a half whose dirty flag (bit 1) is clear returns code 3 (modified). The checks are made in a fixed order: valid, then no-execute, then no-read, then dirty. Code 0 (match) is returned only when all checks pass.
- R9: `rs_writable` is 1 only for code 0, and only when the chosen half's dirty flag is set. `rs_paddr` is zero for every code other than 0.
- R10: When several slots hit, the slot with the lowest index supplies the result.
- R11: A write through the port takes effect on the clock edge where `wr_en` is high. A lookup sampled on that same edge still sees the old slot contents. Lookups sampled on later edges see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one slot on this edge |
| wr_idx | input | IDX_W | Index of the slot to write |
| wr_vpn | input | 32 | Virtual page field of the slot |
| wr_mask | input | 32 | Page-size mask of the slot |
| wr_asid | input | 8 | Address-space tag of the slot |
| wr_global | input | 1 | Global flag: hit for any tag |
| wr_inval | input | 1 | Invalidate flag: slot never hits |
| wr_pfn_even | input | 32 | Physical frame base of the even half |
| wr_flags_even | input | 4 | Even-half flags {no-read, no-exec, dirty, valid} |
| wr_pfn_odd | input | 32 | Physical frame base of the odd half |
| wr_flags_odd | input | 4 | Odd-half flags {no-read, no-exec, dirty, valid} |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| rs_valid | output | 1 | Result fields are valid |
| rs_code | output | 3 | 0 match, 1 no match, 2 invalid, 3 modified, 4 no-exec, 5 no-read |
| rs_paddr | output | 32 | Translated physical address |
| rs_writable | output | 1 | Translated page may be written |

## Verification
Every lookup result is due exactly one rising edge after the falling edge on which the bench drives the request. Slot writes are due on the rising edge that samples `wr_en`, so a lookup driven on that same falling edge must still return the old contents. The driver pushes one expected entry per request into a queue. The monitor samples the registered outputs on each falling edge and pops an entry whenever `rs_valid` is high, so each result is compared in the cycle it becomes due and never earlier. A result with no queued expectation, or an expectation left in the queue at the end, counts as a failure.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int TLB_AW     = 32;
  localparam int TLB_ASID_W = 8;
  localparam int TLB_FL_W   = 4;

  // flag bit positions within a half-page flag nibble
  localparam int FL_V  = 0;
  localparam int FL_D  = 1;
  localparam int FL_XI = 2;
  localparam int FL_RI = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    RES_MATCH    = 3'd0,
    RES_NOMATCH  = 3'd1,
    RES_INVALID  = 3'd2,
    RES_MODIFIED = 3'd3,
    RES_XINH     = 3'd4,
    RES_RINH     = 3'd5
  } res_e;

  typedef struct packed {
    logic [TLB_AW-1:0]   pfn;
    logic [TLB_FL_W-1:0] fl;
  } half_t;

  typedef struct packed {
    logic [TLB_AW-1:0]     vpn;
    logic [TLB_AW-1:0]     mask;
    logic [TLB_ASID_W-1:0] asid;
    logic                  glb;
    logic                  inval;
    half_t                 ev;
    half_t                 od;
  } entry_t;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_data,
  output entry_t           ents [NUM_ENTRIES]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ents[i]       <= '0;
        ents[i].inval <= 1'b1;
      end
    end else if (wr_en) begin
      ents[wr_idx] <= wr_data;
    end
  end

  logic all_inval;
  always_comb begin
    all_inval = 1'b1;
    for (int i = 0; i < NUM_ENTRIES; i++) all_inval = all_inval & ents[i].inval;
  end

  // after reset no slot may hit
  p_reset_clears_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> all_inval);

  // a written slot holds the written contents on the following edge
  p_write_lands_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ents[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_pkg::*;
#(
  parameter int MIN_PAGE_BITS = 12,
  localparam logic [TLB_AW-1:0] MIN_MASK = TLB_AW'((64'd1 << (MIN_PAGE_BITS + 1)) - 64'd1)
) (
  input  entry_t                ent,
  input  logic [TLB_AW-1:0]     vaddr,
  input  logic [TLB_ASID_W-1:0] asid,
  output logic                  hit,
  output half_t                 sel,
  output logic [TLB_AW-1:0]     off
);

  logic [TLB_AW-1:0] msk, half_msk, pick_bit;
  logic              asid_ok, tag_ok, odd;

  always_comb begin
    msk      = ent.mask | MIN_MASK;
    half_msk = msk >> 1;
    pick_bit = msk & ~half_msk;
    asid_ok  = ent.glb || (ent.asid == asid);
    tag_ok   = (vaddr & ~msk) == (ent.vpn & ~msk);
    hit      = asid_ok && tag_ok && !ent.inval;
    odd      = |(vaddr & pick_bit);
    sel      = odd ? ent.od : ent.ev;
    off      = vaddr & half_msk;
  end

endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0] hit,
  output logic                   any,
  output logic [IDX_W-1:0]       idx
);

  always_comb begin
    any = |hit;
    idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES   = 16,
  parameter int MIN_PAGE_BITS = 12,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [TLB_AW-1:0]     wr_vpn,
  input  logic [TLB_AW-1:0]     wr_mask,
  input  logic [TLB_ASID_W-1:0] wr_asid,
  input  logic                  wr_global,
  input  logic                  wr_inval,
  input  logic [TLB_AW-1:0]     wr_pfn_even,
  input  logic [TLB_FL_W-1:0]   wr_flags_even,
  input  logic [TLB_AW-1:0]     wr_pfn_odd,
  input  logic [TLB_FL_W-1:0]   wr_flags_odd,
  input  logic                  lk_req,
  input  logic [TLB_AW-1:0]     lk_vaddr,
  input  logic [TLB_ASID_W-1:0] lk_asid,
  input  logic [1:0]            lk_acc,
  output logic                  rs_valid,
  output logic [2:0]            rs_code,
  output logic [TLB_AW-1:0]     rs_paddr,
  output logic                  rs_writable
);

  entry_t wr_ent;
  entry_t ents [NUM_ENTRIES];

  always_comb begin
    wr_ent.vpn   = wr_vpn;
    wr_ent.mask  = wr_mask;
    wr_ent.asid  = wr_asid;
    wr_ent.glb   = wr_global;
    wr_ent.inval = wr_inval;
    wr_ent.ev    = '{pfn: wr_pfn_even, fl: wr_flags_even};
    wr_ent.od    = '{pfn: wr_pfn_odd,  fl: wr_flags_odd};
  end

  tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_ent),
    .ents    (ents)
  );

  logic [NUM_ENTRIES-1:0] hit;
  half_t                  sel_half [NUM_ENTRIES];
  logic [TLB_AW-1:0]      sel_off  [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    tlb_entry_cmp #(.MIN_PAGE_BITS(MIN_PAGE_BITS)) u_cmp (
      .ent   (ents[g]),
      .vaddr (lk_vaddr),
      .asid  (lk_asid),
      .hit   (hit[g]),
      .sel   (sel_half[g]),
      .off   (sel_off[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;

  tlb_prio_sel #(.NUM_ENTRIES(NUM_ENTRIES)) u_prio (
    .hit (hit),
    .any (any_hit),
    .idx (win_idx)
  );

  // permission decode: valid, no-exec, no-read, dirty in that order
  half_t             h;
  res_e              code_n;
  logic [TLB_AW-1:0] pa_n;
  logic              wrb_n;
  logic              is_fetch, is_store, is_load;

  always_comb begin
    is_fetch = (lk_acc == ACC_FETCH);
    is_store = (lk_acc == ACC_STORE);
    is_load  = !is_fetch && !is_store;
    h        = sel_half[win_idx];
    code_n   = RES_NOMATCH;
    pa_n     = '0;
    wrb_n    = 1'b0;
    if (any_hit) begin
      if (!h.fl[FL_V])                       code_n = RES_INVALID;
      else if (is_fetch && h.fl[FL_XI])      code_n = RES_XINH;
      else if (is_load && h.fl[FL_RI])       code_n = RES_RINH;
      else if (is_store && !h.fl[FL_D])      code_n = RES_MODIFIED;
      else begin
        code_n = RES_MATCH;
        pa_n   = h.pfn | sel_off[win_idx];
        wrb_n  = h.fl[FL_D];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid    <= 1'b0;
      rs_code     <= RES_NOMATCH;
      rs_paddr    <= '0;
      rs_writable <= 1'b0;
    end else begin
      rs_valid <= lk_req;
      if (lk_req) begin
        rs_code     <= code_n;
        rs_paddr    <= pa_n;
        rs_writable <= wrb_n;
      end
    end
  end

  p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rs_valid);

  p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rs_valid);

  p_writable_only_match_r9: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_writable) |-> (rs_code == RES_MATCH));

  p_fault_paddr_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_code != RES_MATCH) |-> (rs_paddr == '0));

  p_xinh_only_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_acc != ACC_FETCH) |=> (rs_code != RES_XINH));

  p_rinh_only_load_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_req && (lk_acc == ACC_FETCH || lk_acc == ACC_STORE)) |=> (rs_code != RES_RINH));

  p_modified_only_store_r8: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_acc != ACC_STORE) |=> (rs_code != RES_MODIFIED));

endmodule

// File: tb/sim_tlb_lookup_unit.sv
module sim_tlb_lookup_unit;

  localparam int N     = 16;
  localparam int IDX_W = $clog2(N);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [31:0]      wr_vpn = '0, wr_mask = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
  logic [7:0]       wr_asid = '0;
  logic             wr_global = 1'b0, wr_inval = 1'b0;
  logic [3:0]       wr_flags_even = '0, wr_flags_odd = '0;
  logic             lk_req = 1'b0;
  logic [31:0]      lk_vaddr = '0;
  logic [7:0]       lk_asid = '0;
  logic [1:0]       lk_acc = '0;
  logic             rs_valid;
  logic [2:0]       rs_code;
  logic [31:0]      rs_paddr;
  logic             rs_writable;

  always #2 clk = ~clk;

  tlb_lookup_unit #(.NUM_ENTRIES(N)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_global(wr_global), .wr_inval(wr_inval),
    .wr_pfn_even(wr_pfn_even), .wr_flags_even(wr_flags_even),
    .wr_pfn_odd(wr_pfn_odd), .wr_flags_odd(wr_flags_odd),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_acc(lk_acc),
    .rs_valid(rs_valid), .rs_code(rs_code), .rs_paddr(rs_paddr), .rs_writable(rs_writable)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;

  logic [2:0]  code_q [$];
  logic [31:0] pa_q   [$];
  logic        wr_q   [$];
  string       tag_q  [$];

  localparam logic [1:0] FETCH = 2'd0, LOAD = 2'd1, STORE = 2'd2;
  localparam logic [2:0] C_OK = 3'd0, C_MISS = 3'd1, C_INV = 3'd2, C_MOD = 3'd3,
                         C_XI = 3'd4, C_RI = 3'd5;

  task automatic write_entry(input int idx, input logic [31:0] vpn, input logic [31:0] msk,
                             input logic [7:0] asid, input logic glb, input logic inv,
                             input logic [31:0] pfe, input logic [3:0] fle,
                             input logic [31:0] pfo, input logic [3:0] flo);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_vpn = vpn; wr_mask = msk; wr_asid = asid;
    wr_global = glb; wr_inval = inv; wr_pfn_even = pfe; wr_flags_even = fle;
    wr_pfn_odd = pfo; wr_flags_odd = flo;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc,
                        input logic [2:0] ecode, input logic [31:0] epa, input logic ewr,
                        input string tag);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_asid = asid; lk_acc = acc;
    code_q.push_back(ecode); pa_q.push_back(epa); wr_q.push_back(ewr); tag_q.push_back(tag);
    @(posedge clk); #1;
    lk_req = 1'b0;
  endtask

  // monitor: compare each result in the cycle it becomes due
  always @(negedge clk) begin
    if (!rst && rs_valid) begin
      n_checks++;
      if (code_q.size() == 0) begin
        n_fails++;
        $display("FAIL R1 unexpected result: actual valid=1 expected valid=0");
      end else begin
        logic [2:0]  ec;
        logic [31:0] ep;
        logic        ew;
        string       t;
        ec = code_q.pop_front(); ep = pa_q.pop_front();
        ew = wr_q.pop_front();   t  = tag_q.pop_front();
        if (rs_code !== ec || rs_paddr !== ep || rs_writable !== ew) begin
          n_fails++;
          $display("FAIL %s: actual code=%0d pa=%h wr=%b expected code=%0d pa=%h wr=%b",
                   t, rs_code, rs_paddr, rs_writable, ec, ep, ew);
        end
      end
    end
  end

  initial begin
    // R2: outputs idle during reset
    repeat (3) @(negedge clk);
    n_checks++;
    if (rs_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R2 reset: actual valid=%b expected valid=0", rs_valid);
    end
    rst = 1'b0;

    lookup(32'h0000_0000, 8'd0, LOAD, C_MISS, 32'h0, 1'b0, "R2 empty after reset");

    // slot 0: tag 5, 8 KB pair at 0x0040_0000
    write_entry(0, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h1000_0000, 4'h3, 32'h2000_0000, 4'h1);
    lookup(32'h0040_0123, 8'd5, LOAD,  C_OK,   32'h1000_0123, 1'b1, "R5 even half");
    lookup(32'h0040_1456, 8'd5, LOAD,  C_OK,   32'h2000_0456, 1'b0, "R9 odd clean load");
    lookup(32'h0040_1456, 8'd5, STORE, C_MOD,  32'h0,         1'b0, "R8 store clean");
    lookup(32'h0040_0123, 8'd6, LOAD,  C_MISS, 32'h0,         1'b0, "R3 tag mismatch");
    lookup(32'h0040_2000, 8'd5, LOAD,  C_MISS, 32'h0,         1'b0, "R3 outside pair");

    // slot 1: global, 64 KB halves at 0x0080_0000
    write_entry(1, 32'h0080_0000, 32'h0001_E000, 8'd0, 1'b1, 1'b0, 32'h3000_0000, 4'h7, 32'h4000_0000, 4'h9);
    lookup(32'h0080_ABCD, 8'h77, LOAD,  C_OK,   32'h3000_ABCD, 1'b1, "R4 large even half");
    lookup(32'h0080_ABCD, 8'h77, FETCH, C_XI,   32'h0,         1'b0, "R7 fetch no-exec");
    lookup(32'h0080_ABCD, 8'h77, STORE, C_OK,   32'h3000_ABCD, 1'b1, "R7 store ignores no-exec");
    lookup(32'h0081_2345, 8'h01, LOAD,  C_RI,   32'h0,         1'b0, "R7 load no-read");
    lookup(32'h0081_2345, 8'h01, 2'd3,  C_RI,   32'h0,         1'b0, "R7 kind 3 as load");
    lookup(32'h0081_2345, 8'h01, FETCH, C_OK,   32'h4000_2345, 1'b0, "R7 fetch ignores no-read");
    lookup(32'h0081_2345, 8'h01, STORE, C_MOD,  32'h0,         1'b0, "R8 no-read then dirty");
    lookup(32'h0082_0000, 8'h01, LOAD,  C_MISS, 32'h0,         1'b0, "R4 bit above mask");

    // slot 2: even half invalid but no-exec set
    write_entry(2, 32'h0100_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h5500_0000, 4'h4, 32'h5600_0000, 4'h3);
    lookup(32'h0100_0010, 8'd5, FETCH, C_INV, 32'h0, 1'b0, "R6 invalid before no-exec");
    lookup(32'h0100_0010, 8'd5, STORE, C_INV, 32'h0, 1'b0, "R6 invalid on store");

    // slot 3: invalidate flag set
    write_entry(3, 32'h0200_0000, 32'h0, 8'd0, 1'b1, 1'b1, 32'h5700_0000, 4'h3, 32'h5800_0000, 4'h3);
    lookup(32'h0200_0000, 8'd0, LOAD, C_MISS, 32'h0, 1'b0, "R3 invalidated slot");

    // slots 5 and 9 overlap
    write_entry(9, 32'h0300_0000, 32'h0, 8'd0, 1'b1, 1'b0, 32'h6000_0000, 4'h3, 32'h6100_0000, 4'h3);
    write_entry(5, 32'h0300_0000, 32'h0, 8'd0, 1'b1, 1'b0, 32'h5000_0000, 4'h3, 32'h5100_0000, 4'h3);
    lookup(32'h0300_0040, 8'd9, LOAD, C_OK, 32'h5000_0040, 1'b1, "R10 lowest index wins");
    write_entry(5, 32'h0300_0000, 32'h0, 8'd0, 1'b1, 1'b1, 32'h5000_0000, 4'h3, 32'h5100_0000, 4'h3);
    lookup(32'h0300_0040, 8'd9, LOAD, C_OK, 32'h6000_0040, 1'b1, "R10 next index after invalidate");

    // R11: lookup on the write edge sees old contents
    fork
      write_entry(7, 32'h0400_0000, 32'h0, 8'd2, 1'b0, 1'b0, 32'h7000_0000, 4'h3, 32'h7100_0000, 4'h3);
      lookup(32'h0400_0000, 8'd2, LOAD, C_MISS, 32'h0, 1'b0, "R11 same edge old contents");
    join
    lookup(32'h0400_0000, 8'd2, LOAD, C_OK, 32'h7000_0000, 1'b1, "R11 next edge new contents");
    lookup(32'h0400_1008, 8'd2, STORE, C_OK, 32'h7100_0008, 1'b1, "R5 odd dirty store");

    repeat (4) @(negedge clk);
    n_checks++;
    if (code_q.size() != 0) begin
      n_fails++;
      $display("FAIL R1 missing results: actual pending=%0d expected pending=0", code_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule